// File: doc/BRIEF.md
# Stereo Output Router with Soft Mute and Zero-Run Automute

This block takes one signed left/right sample pair per strobe and produces the sample pairs sent to three stereo output stages. A four-bit routing code chooses the source of each output channel independently. The choices are silence, the left input, the right input, or the average of the two. Each output pair can then be sign-inverted on its own. A linear gain multiply applies the per-channel attenuation and a gain envelope. The envelope ramps down when muting and back up when unmuting, so there are no clicks. A power-down input forces every output to silence at once.

The gain envelope steps toward zero while the soft-mute input is set. It also steps toward zero while the zero-run detector reports a long stretch of all-zero input. The detector has its own enable. The control inputs are static levels held by the surrounding control register. Their usual reset values are: routing code `ROUTE_STEREO` (4'b1001, straight stereo) from the package, phase mask zero, mute, power-down and detector enable all zero.

Top module: `stereo_route_mute`

## Requirements
- R1: The routing code bits [1:0] choose the left output source and bits [3:2] choose the right output source. The encoding is 00 silence, 01 left input, 10 right input, 11 average. Every output pair carries the same routed channels.
- R2: The average is floor((L+R)/2), formed at one bit wider than a sample. It never wraps, even for two full-scale inputs of the same sign.
- R3: Bit p of the phase mask negates both channels of output pair p. The most negative code maps to the most positive code.
- R4: While power-down is high, an accepted pair produces all-zero outputs.
- R5: The envelope E runs from 0 to RAMP_LEN (256). Each accepted pair uses the current E. After that pair, E moves by one: toward 0 while muting is requested, toward RAMP_LEN otherwise. It holds at its limits.
- R6: The channel gain is g = floor((att+1)·E/256). The output is floor(src·g/256). With att 255 and E 256 the output equals the source. When attenuation tracking is high, the right channels use the left attenuation.
- R7: With the detector enabled, the zero-run flag rises after the 1024th consecutive accepted pair whose two inputs are both zero. It falls after the first accepted pair with a nonzero input. With the detector disabled, the flag stays low.
- R8: A high zero-run flag requests muting of the envelope in the same way as the soft-mute input.
- R9: The outputs and out_valid update one clock after an accepted pair. With no strobe, the outputs hold and out_valid stays low.
- R10: After reset, the outputs, out_valid and the zero-run flag are zero, and E is at RAMP_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: in_l/in_r hold a new pair |
| in_l | input | DW | Left input sample, signed |
| in_r | input | DW | Right input sample, signed |
| route | input | 4 | Routing code, [1:0] left source, [3:2] right source |
| soft_mute | input | 1 | Request ramped mute |
| power_down | input | 1 | Force all outputs to zero |
| att_track | input | 1 | Right channels use att_l |
| zd_en | input | 1 | Zero-run detector enable |
| phase_inv | input | NPAIR | Per-pair sign inversion mask |
| att_l | input | ATT_W | Left attenuation code |
| att_r | input | ATT_W | Right attenuation code |
| out_valid | output | 1 | Output pairs updated this cycle |
| out_l | output | NPAIR*DW | Left outputs, pair p at [p*DW +: DW] |
| out_r | output | NPAIR*DW | Right outputs, pair p at [p*DW +: DW] |
| zero_flag | output | 1 | Zero-run detected |

## Verification
The zero-run flag and the gain envelope can meet in one accepted pair. This happens when the first nonzero pair follows a long silent run. That pair clears the flag, but it is still scaled by the envelope that the automute drove toward zero. The bench provokes this by feeding enough zero pairs to raise the flag and empty the envelope, then sending a loud pair. It expects silence and a low flag in the same output cycle, and then the envelope climbing one step per pair.

// File: rtl/srm_pkg.sv
package srm_pkg;
   typedef enum logic [1:0] {
      SRC_MUTE  = 2'b00,
      SRC_LEFT  = 2'b01,
      SRC_RIGHT = 2'b10,
      SRC_AVG   = 2'b11
   } src_sel_e;

   localparam logic [3:0] ROUTE_STEREO = 4'b1001;
endpackage

// File: rtl/srm_route.sv
module srm_route
   import srm_pkg::*;
#(
   parameter int DW = 24
) (
   input  src_sel_e              sel,
   input  logic signed [DW-1:0]  in_l,
   input  logic signed [DW-1:0]  in_r,
   output logic signed [DW-1:0]  src
);
   logic [DW:0] sum_w;

   // one guard bit, so a same-sign full-scale pair cannot wrap
   assign sum_w = {in_l[DW-1], in_l} + {in_r[DW-1], in_r};

   always_comb begin
      unique case (sel)
         SRC_MUTE:  src = '0;
         SRC_LEFT:  src = in_l;
         SRC_RIGHT: src = in_r;
         default:   src = DW'(sum_w >> 1);
      endcase
   end
endmodule

// File: rtl/srm_gain.sv
module srm_gain #(
   parameter int DW       = 24,
   parameter int ATT_W    = 8,
   parameter int RAMP_LEN = 256,
   parameter bit SAT_INV  = 1'b1,
   localparam int RSH     = $clog2(RAMP_LEN),
   localparam int RAMP_W  = RSH + 1
) (
   input  logic signed [DW-1:0]  sample,
   input  logic [ATT_W-1:0]      att,
   input  logic [RAMP_W-1:0]     ramp,
   input  logic                  invert,
   input  logic                  pdn,
   output logic signed [DW-1:0]  y
);
   localparam int GW = ATT_W + 1;
   localparam int PW = GW + RAMP_W;
   localparam int XW = DW + GW + 1;
   localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [DW-1:0] MAXV = ~MINV;

   logic [PW-1:0]          att_p1, gprod;
   logic [GW-1:0]          g;
   logic signed [XW-1:0]   s_ext, g_ext, prod;
   logic signed [DW-1:0]   y0, neg;

   assign att_p1 = PW'(att) + PW'(1);
   assign gprod  = att_p1 * PW'(ramp);
   assign g      = GW'(gprod >> RSH);

   assign s_ext  = XW'(sample);
   assign g_ext  = $signed(XW'(g));
   assign prod   = s_ext * g_ext;
   assign y0     = DW'(prod >>> ATT_W);

   generate
      if (SAT_INV) begin : g_sat
         assign neg = (y0 == MINV) ? MAXV : -y0;
      end else begin : g_wrap
         assign neg = -y0;
      end
   endgenerate

   assign y = pdn ? '0 : (invert ? neg : y0);
endmodule

// File: rtl/srm_zero_det.sv
module srm_zero_det #(
   parameter int DW       = 24,
   parameter int ZERO_RUN = 1024
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic signed [DW-1:0]  in_l,
   input  logic signed [DW-1:0]  in_r,
   input  logic                  enable,
   output logic                  flag
);
   localparam int CW = $clog2(ZERO_RUN + 1);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
      end else if (in_valid) begin
         if (in_l == '0 && in_r == '0) begin
            if (run_cnt != CW'(ZERO_RUN)) run_cnt <= run_cnt + 1'b1;
         end else begin
            run_cnt <= '0;
         end
      end
   end

   assign flag = enable && (run_cnt == CW'(ZERO_RUN));
endmodule

// File: rtl/srm_ramp.sv
module srm_ramp #(
   parameter int RAMP_LEN = 256,
   localparam int RAMP_W  = $clog2(RAMP_LEN) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               mute,
   output logic [RAMP_W-1:0]  ramp
);
   localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ramp <= TOP;
      end else if (step) begin
         if (mute) begin
            if (ramp != '0) ramp <= ramp - 1'b1;
         end else if (ramp != TOP) begin
            ramp <= ramp + 1'b1;
         end
      end
   end
endmodule

// File: rtl/stereo_route_mute.sv
module stereo_route_mute
   import srm_pkg::*;
#(
   parameter int DW       = 24,
   parameter int NPAIR    = 3,
   parameter int ATT_W    = 8,
   parameter int RAMP_LEN = 256,
   parameter int ZERO_RUN = 1024,
   parameter bit SAT_INV  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DW-1:0]     in_l,
   input  logic signed [DW-1:0]     in_r,
   input  logic [3:0]               route,
   input  logic                     soft_mute,
   input  logic                     power_down,
   input  logic                     att_track,
   input  logic                     zd_en,
   input  logic [NPAIR-1:0]         phase_inv,
   input  logic [ATT_W-1:0]         att_l,
   input  logic [ATT_W-1:0]         att_r,
   output logic                     out_valid,
   output logic [NPAIR*DW-1:0]      out_l,
   output logic [NPAIR*DW-1:0]      out_r,
   output logic                     zero_flag
);
   localparam int RAMP_W = $clog2(RAMP_LEN) + 1;

   generate
      if (DW < 8) begin : g_bad_dw
         $error("stereo_route_mute: DW must be at least 8");
      end
      if (NPAIR < 1 || NPAIR > 8) begin : g_bad_np
         $error("stereo_route_mute: NPAIR must be 1..8");
      end
      if (RAMP_LEN < 2 || (RAMP_LEN & (RAMP_LEN - 1)) != 0) begin : g_bad_ramp
         $error("stereo_route_mute: RAMP_LEN must be a power of two >= 2");
      end
      if (ATT_W < 2) begin : g_bad_att
         $error("stereo_route_mute: ATT_W must be at least 2");
      end
      if (ZERO_RUN < 2) begin : g_bad_zr
         $error("stereo_route_mute: ZERO_RUN must be at least 2");
      end
   endgenerate

   logic [RAMP_W-1:0]      gain_ramp;
   logic signed [DW-1:0]   src_l, src_r;
   logic [NPAIR*DW-1:0]    nxt_l, nxt_r;
   logic [ATT_W-1:0]       att_r_eff;

   assign att_r_eff = att_track ? att_l : att_r;

   srm_route #(.DW(DW)) u_route_l (
      .sel(src_sel_e'(route[1:0])), .in_l(in_l), .in_r(in_r), .src(src_l));
   srm_route #(.DW(DW)) u_route_r (
      .sel(src_sel_e'(route[3:2])), .in_l(in_l), .in_r(in_r), .src(src_r));

   generate
      for (genvar p = 0; p < NPAIR; p++) begin : g_pair
         srm_gain #(.DW(DW), .ATT_W(ATT_W), .RAMP_LEN(RAMP_LEN), .SAT_INV(SAT_INV)) u_gain_l (
            .sample(src_l), .att(att_l), .ramp(gain_ramp),
            .invert(phase_inv[p]), .pdn(power_down), .y(nxt_l[p*DW +: DW]));
         srm_gain #(.DW(DW), .ATT_W(ATT_W), .RAMP_LEN(RAMP_LEN), .SAT_INV(SAT_INV)) u_gain_r (
            .sample(src_r), .att(att_r_eff), .ramp(gain_ramp),
            .invert(phase_inv[p]), .pdn(power_down), .y(nxt_r[p*DW +: DW]));
      end
   endgenerate

   srm_zero_det #(.DW(DW), .ZERO_RUN(ZERO_RUN)) u_zdet (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_l(in_l), .in_r(in_r), .enable(zd_en), .flag(zero_flag));

   srm_ramp #(.RAMP_LEN(RAMP_LEN)) u_ramp (
      .clk(clk), .rst_n(rst_n), .step(in_valid),
      .mute(soft_mute | zero_flag), .ramp(gain_ramp));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_l     <= '0;
         out_r     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_l <= nxt_l;
            out_r <= nxt_r;
         end
      end
   end
endmodule

// File: rtl/srm_chk.sv
module srm_chk #(
   parameter int DW       = 24,
   parameter int NPAIR    = 3,
   parameter int RAMP_LEN = 256,
   localparam int RAMP_W  = $clog2(RAMP_LEN) + 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic signed [DW-1:0]  in_l,
   input logic signed [DW-1:0]  in_r,
   input logic                  power_down,
   input logic                  zd_en,
   input logic                  out_valid,
   input logic [NPAIR*DW-1:0]   out_l,
   input logic [NPAIR*DW-1:0]   out_r,
   input logic                  zero_flag,
   input logic [RAMP_W-1:0]     gain_ramp
);
   // R9
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_l) && $stable(out_r)));
   // R4
   pdn_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && power_down) |=> (out_l == '0 && out_r == '0));
   // R7
   zd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zd_en |-> !zero_flag);
   // R7
   zd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero_flag && in_valid && (in_l != '0 || in_r != '0)) |=> !zero_flag);
   // R5
   ramp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gain_ramp <= RAMP_W'(RAMP_LEN));
   // R5
   ramp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(gain_ramp));
endmodule

bind stereo_route_mute srm_chk #(.DW(DW), .NPAIR(NPAIR), .RAMP_LEN(RAMP_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
   .power_down(power_down), .zd_en(zd_en), .out_valid(out_valid),
   .out_l(out_l), .out_r(out_r), .zero_flag(zero_flag), .gain_ramp(gain_ramp));

// File: tb/sim_stereo_route_mute.sv
`timescale 1ns/1ps
module sim_stereo_route_mute;
   localparam int DW = 24, NPAIR = 3, ATT_W = 8, RLEN = 256, ZRUN = 1024;
   localparam longint SMAX = (64'sd1 <<< (DW-1)) - 1;
   localparam longint SMIN = -(64'sd1 <<< (DW-1));

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic signed [DW-1:0] in_l = '0, in_r = '0;
   logic [3:0] route = 4'b1001;
   logic soft_mute = 0, power_down = 0, att_track = 0, zd_en = 0;
   logic [NPAIR-1:0] phase_inv = '0;
   logic [ATT_W-1:0] att_l = 8'd255, att_r = 8'd255;
   logic out_valid, zero_flag;
   logic [NPAIR*DW-1:0] out_l, out_r;

   int n_chk = 0, n_bad = 0;
   int m_ramp = RLEN, m_cnt = 0;

   always #2 clk = ~clk;

   stereo_route_mute u0 (.*);

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic longint pick(input logic [1:0] s, input longint l, input longint r);
      case (s)
         2'b00: return 0;
         2'b01: return l;
         2'b10: return r;
         default: return (l + r) >>> 1;
      endcase
   endfunction

   function automatic longint scale(input longint s, input int att, input int e, input bit inv);
      longint g = ((longint'(att) + 1) * e) >>> 8;
      longint y = (s * g) >>> 8;
      if (power_down) return 0;
      if (inv) y = (y == SMIN) ? SMAX : -y;
      return y;
   endfunction

   task automatic send(input longint l, input longint r, input string req);
      longint el[NPAIR], er[NPAIR];
      bit flag_now;
      for (int p = 0; p < NPAIR; p++) begin
         el[p] = scale(pick(route[1:0], l, r), att_l, m_ramp, phase_inv[p]);
         er[p] = scale(pick(route[3:2], l, r), att_track ? att_l : att_r, m_ramp, phase_inv[p]);
      end
      @(negedge clk);
      in_l = DW'(l); in_r = DW'(r); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " out_valid (R9)"}, out_valid, 1);
      for (int p = 0; p < NPAIR; p++) begin
         chk({req, " left"},  longint'($signed(out_l[p*DW +: DW])), el[p]);
         chk({req, " right"}, longint'($signed(out_r[p*DW +: DW])), er[p]);
      end
      flag_now = zd_en && (m_cnt == ZRUN);
      if (soft_mute || flag_now) begin
         if (m_ramp > 0) m_ramp--;
      end else if (m_ramp < RLEN) m_ramp++;
      if (l == 0 && r == 0) begin
         if (m_cnt < ZRUN) m_cnt++;
      end else m_cnt = 0;
      chk({req, " zero_flag"}, zero_flag, (zd_en && m_cnt == ZRUN) ? 1 : 0);
   endtask

   task automatic t_reset;
      chk("R10 out_valid", out_valid, 0);
      chk("R10 out_l", out_l, 0);
      chk("R10 out_r", out_r, 0);
      chk("R10 zero_flag", zero_flag, 0);
      send(12345, -54321, "R10 full gain");
   endtask

   task automatic t_route;
      for (int c = 0; c < 16; c++) begin
         route = 4'(c);
         send(1000, -3001, "R1 route");
         send(SMAX, SMIN, "R1 route extremes");
      end
      route = 4'b1001;
   endtask

   task automatic t_avg;
      route = 4'b1111;
      send(SMAX, SMAX, "R2 avg pos full");
      send(SMIN, SMIN, "R2 avg neg full");
      send(-3, 0, "R2 avg floor neg");
      send(3, 0, "R2 avg floor pos");
      send(SMAX, SMIN, "R2 avg mixed");
      route = 4'b1001;
   endtask

   task automatic t_phase;
      for (int m = 1; m < 8; m++) begin
         phase_inv = 3'(m);
         send(SMIN, 777, "R3 phase");
         send(-4242, SMAX, "R3 phase");
      end
      phase_inv = '0;
   endtask

   task automatic t_atten;
      att_l = 8'd127; att_r = 8'd63;
      send(100000, -100000, "R6 own atten");
      att_track = 1'b1;
      send(100000, -100000, "R6 tracking");
      att_l = 8'd0;
      send(SMAX, SMIN, "R6 tracking min");
      att_track = 1'b0; att_l = 8'd255; att_r = 8'd255;
      send(SMAX, SMIN, "R6 unity");
   endtask

   task automatic t_pdn;
      power_down = 1'b1;
      send(SMAX, -99, "R4 power-down");
      send(5, 6, "R4 power-down");
      power_down = 1'b0;
      send(5, 6, "R4 released");
   endtask

   task automatic t_idle;
      logic [NPAIR*DW-1:0] hl, hr;
      send(2222, -3333, "R9 setup");
      hl = out_l; hr = out_r;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         in_l = DW'(i * 77 + 1); in_r = DW'(-i - 9);
         chk("R9 idle out_valid", out_valid, 0);
         chk("R9 idle hold l", (out_l == hl) ? 1 : 0, 1);
         chk("R9 idle hold r", (out_r == hr) ? 1 : 0, 1);
      end
   endtask

   task automatic t_softmute;
      soft_mute = 1'b1;
      for (int i = 0; i < RLEN + 4; i++) send(200000, -150000, "R5 ramp down");
      soft_mute = 1'b0;
      for (int i = 0; i < RLEN + 4; i++) send(200000, -150000, "R5 ramp up");
   endtask

   task automatic t_zero;
      zd_en = 1'b0;
      for (int i = 0; i < ZRUN + 20; i++) send(0, 0, "R7 disabled");
      zd_en = 1'b1;
      send(1, 0, "R7 restart run");
      for (int i = 0; i < ZRUN - 1; i++) send(0, 0, "R7 run");
      chk("R7 flag before limit", zero_flag, 0);
      send(0, 0, "R7 run limit");
      chk("R7 flag at limit", zero_flag, 1);
      for (int i = 0; i < RLEN + 10; i++) send(0, 0, "R8 automute");
      send(50000, 50000, "R8 first loud pair");
      chk("R7 flag cleared", zero_flag, 0);
      for (int i = 0; i < RLEN + 4; i++) send(50000, -70000, "R8 recovery");
      zd_en = 1'b0;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_route();
      t_avg();
      t_phase();
      t_atten();
      t_pdn();
      t_idle();
      t_softmute();
      t_zero();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule